// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the two ALU operands for the execute stage of a five-stage in-order pipeline. The pipeline's register file cannot hand a value written in one cycle to a read in that same cycle, so the pipeline keeps one extra register after writeback, called the WB/END register here. That register holds the result of the instruction that has just left writeback.

The block compares the two source register fields of the instruction in ID/EX against the destinations of three older instructions: the ones in EX/MEM, MEM/WB and WB/END. Each operand takes the result of the youngest older instruction that writes its register. If no older instruction writes that register, the operand takes the value read from the register file during decode.

The block is purely combinational. For each operand it reports a select code along with the operand value.

Top module: `fwd_unit`

Instruction word fields: the opcode is in bits 24:22, field A in bits 21:19, field B in bits 18:16, and the R-type destination in bits 2:0. Opcodes are: add=0, nor=1, load=2, store=3, branch=4, jump-and-link=5, halt=6, no-op=7. The no-op word is 0x1C00000. Select codes are: 0 = register file, 1 = EX/MEM, 2 = MEM/WB, 3 = WB/END.

## Requirements
- R1: An operand whose register matches no producer drives the register-file value, with select code 0.
- R2: An add (opcode 0) or nor (opcode 1) in EX/MEM whose bits 2:0 equal the operand's register supplies the EX/MEM result, with select code 1.
- R3: A load (opcode 2) writes the register named in bits 18:16, and only that register. It is a producer for that register alone.
- R4: A matching producer in MEM/WB, with no match in EX/MEM, supplies the MEM/WB result, with select code 2.
- R5: A matching producer in WB/END, with no match in the two younger stages, supplies the WB/END result, with select code 3.
- R6: When several stages match, EX/MEM wins over MEM/WB, and MEM/WB wins over WB/END.
- R7: A store (3), branch (4), jump-and-link (5), halt (6) or no-op (7, word 0x1C00000) never supplies a value, whatever its fields hold.
- R8: A source register of 0 always takes the register-file value, with select code 0, even when a producer names register 0.
- R9: Operand A uses the ID/EX field in bits 21:19 and operand B uses the field in bits 18:16. The two are resolved independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_instr | input | 32 | Instruction word in ID/EX |
| rf_a | input | DATA_W | Register-file value read for field A |
| rf_b | input | DATA_W | Register-file value read for field B |
| exmem_instr | input | 32 | Instruction word in EX/MEM |
| exmem_result | input | DATA_W | Result held in EX/MEM |
| memwb_instr | input | 32 | Instruction word in MEM/WB |
| memwb_result | input | DATA_W | Result held in MEM/WB |
| wbend_instr | input | 32 | Instruction word in WB/END |
| wbend_result | input | DATA_W | Result held in WB/END |
| op_a | output | DATA_W | Resolved ALU operand A |
| op_b | output | DATA_W | Resolved ALU operand B |
| sel_a | output | 2 | Source code for op_a |
| sel_b | output | 2 | Source code for op_b |

## Verification
The hardest case to reach is all three producers naming the same register at once, while the two operands resolve to different stages. In a running pipeline this needs three back-to-back writers to one register followed by a reader. The bench drives the three pipeline words directly, giving every stage the same destination and a distinct result. It then turns the producers into non-writers one at a time, from the youngest down, so that each step of the priority chain shows up at the outputs. Destinations are placed in the load's B field and the R-type low field in turn, which exposes any field mix-up.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_W   = 3;
    localparam int NUM_SRC = 3;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LOAD = 3'd2,
        OP_STOR = 3'd3,
        OP_BRCH = 3'd4,
        OP_JLNK = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2,
        SEL_WBEND = 2'd3
    } src_sel_e;

    function automatic opcode_e get_op(input logic [INSTR_W-1:0] w);
        return opcode_e'(w[24:22]);
    endfunction

    function automatic logic [REG_W-1:0] get_ra(input logic [INSTR_W-1:0] w);
        return w[21:19];
    endfunction

    function automatic logic [REG_W-1:0] get_rb(input logic [INSTR_W-1:0] w);
        return w[18:16];
    endfunction
endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
    import fwd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               writes,
    output logic [REG_W-1:0]   dest
);
    always_comb begin
        writes = 1'b0;
        dest   = '0;
        unique case (get_op(instr))
            OP_ADD, OP_NOR: begin
                writes = 1'b1;
                dest   = instr[2:0];
            end
            OP_LOAD: begin
                writes = 1'b1;
                dest   = get_rb(instr);
            end
            default: begin
                writes = 1'b0;
                dest   = '0;
            end
        endcase
        // register 0 is hardwired: a write to it is never a source
        if (dest == '0) writes = 1'b0;
    end

    always_comb begin
        if (get_op(instr) == OP_NOOP || get_op(instr) == OP_STOR ||
            get_op(instr) == OP_BRCH || get_op(instr) == OP_HALT ||
            get_op(instr) == OP_JLNK)
            AST_NONWRITER_SILENT: assert (!writes);  // R7
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]          src_reg,
    input  logic [NUM_SRC-1:0]        writes,
    input  logic [NUM_SRC*REG_W-1:0]  dests,
    input  logic [NUM_SRC*DATA_W-1:0] results,
    input  logic [DATA_W-1:0]         rf_val,
    output src_sel_e                  sel,
    output logic [DATA_W-1:0]         value
);
    logic [NUM_SRC-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_cmp
            assign hit[g] = writes[g] && (src_reg != '0) &&
                            (dests[g*REG_W +: REG_W] == src_reg);
        end
    endgenerate

    always_comb begin
        sel   = SEL_RF;
        value = rf_val;
        // oldest first so the youngest hit overrides
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (hit[k]) begin
                sel   = src_sel_e'(k + 1);
                value = results[k*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        if (hit == '0)
            AST_NO_HIT_USES_RF: assert (sel == SEL_RF && value == rf_val);  // R1
        if (hit[0])
            AST_YOUNGEST_FIRST: assert (sel == SEL_EXMEM);  // R6
        if (src_reg == '0)
            AST_ZERO_NOT_FWD: assert (sel == SEL_RF);  // R8
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       idex_instr,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [31:0]       exmem_instr,
    input  logic [DATA_W-1:0] exmem_result,
    input  logic [31:0]       memwb_instr,
    input  logic [DATA_W-1:0] memwb_result,
    input  logic [31:0]       wbend_instr,
    input  logic [DATA_W-1:0] wbend_result,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    logic [NUM_SRC*INSTR_W-1:0] src_instr;
    logic [NUM_SRC*DATA_W-1:0]  src_result;
    logic [NUM_SRC-1:0]         src_writes;
    logic [NUM_SRC*REG_W-1:0]   src_dest;
    src_sel_e                   sel_a_e, sel_b_e;

    // index 0 is the youngest producer
    assign src_instr  = {wbend_instr, memwb_instr, exmem_instr};
    assign src_result = {wbend_result, memwb_result, exmem_result};

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_dec
            fwd_dest_decode i_dec (
                .instr  (src_instr[g*INSTR_W +: INSTR_W]),
                .writes (src_writes[g]),
                .dest   (src_dest[g*REG_W +: REG_W])
            );
        end
    endgenerate

    fwd_operand_mux #(.DATA_W(DATA_W)) i_mux_a (
        .src_reg (get_ra(idex_instr)),
        .writes  (src_writes),
        .dests   (src_dest),
        .results (src_result),
        .rf_val  (rf_a),
        .sel     (sel_a_e),
        .value   (op_a)
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) i_mux_b (
        .src_reg (get_rb(idex_instr)),
        .writes  (src_writes),
        .dests   (src_dest),
        .results (src_result),
        .rf_val  (rf_b),
        .sel     (sel_b_e),
        .value   (op_b)
    );

    assign sel_a = sel_a_e;
    assign sel_b = sel_b_e;

    always_comb begin
        if (sel_a == SEL_MEMWB)
            AST_MEMWB_VALUE: assert (op_a == memwb_result);  // R4
        if (sel_a == SEL_WBEND)
            AST_WBEND_VALUE: assert (op_a == wbend_result);  // R5
        if (sel_b == SEL_EXMEM)
            AST_EXMEM_VALUE: assert (op_b == exmem_result);  // R2
    end
endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] idex_instr, exmem_instr, memwb_instr, wbend_instr;
    logic [31:0] rf_a, rf_b, exmem_result, memwb_result, wbend_result;
    logic [31:0] op_a, op_b;
    logic [1:0]  sel_a, sel_b;
    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    localparam logic [31:0] NOOP = 32'h01C00000;

    fwd_unit i_fwd_unit (.*);

    function automatic logic [31:0] enc(input int op, input int a, input int b, input int d);
        return {7'd0, 3'(op), 3'(a), 3'(b), 13'd0, 3'(d)};
    endfunction

    task automatic chk(input string req, input logic [31:0] got_v, input logic [31:0] exp_v,
                       input logic [1:0] got_s, input logic [1:0] exp_s);
        checks++;
        if (got_v !== exp_v || got_s !== exp_s) begin
            errors++;
            $display("FAIL %s: value=%h sel=%0d expected value=%h sel=%0d",
                     req, got_v, got_s, exp_v, exp_s);
        end
    endtask

    task automatic setup(input logic [31:0] idx, input logic [31:0] ex,
                         input logic [31:0] mw, input logic [31:0] we);
        @(posedge clk);
        idex_instr = idx; exmem_instr = ex; memwb_instr = mw; wbend_instr = we;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        setup(NOOP, NOOP, NOOP, NOOP);
        chk("R1 a", op_a, rf_a, sel_a, 2'd0);
        chk("R1 b", op_b, rf_b, sel_b, 2'd0);
    endtask

    task automatic t_single_stage;
        setup(enc(0,3,4,1), enc(0,1,1,3), NOOP, NOOP);
        chk("R2 add exmem", op_a, exmem_result, sel_a, 2'd1);
        chk("R9 b untouched", op_b, rf_b, sel_b, 2'd0);
        setup(enc(0,3,4,1), NOOP, enc(1,1,1,4), NOOP);
        chk("R4 nor memwb", op_b, memwb_result, sel_b, 2'd2);
        chk("R9 a untouched", op_a, rf_a, sel_a, 2'd0);
        setup(enc(0,3,4,1), NOOP, NOOP, enc(0,2,2,3));
        chk("R5 wbend", op_a, wbend_result, sel_a, 2'd3);
    endtask

    task automatic t_load_dest;
        // load writes field B (5); its low bits name 3, which must not match
        setup(enc(0,5,3,1), enc(2,0,5,3), NOOP, NOOP);
        chk("R3 load field B", op_a, exmem_result, sel_a, 2'd1);
        chk("R3 not low bits", op_b, rf_b, sel_b, 2'd0);
    endtask

    task automatic t_priority;
        setup(enc(0,6,6,1), enc(0,1,1,6), enc(2,0,6,0), enc(1,2,2,6));
        chk("R6 exmem first", op_a, exmem_result, sel_a, 2'd1);
        setup(enc(0,6,6,1), NOOP, enc(2,0,6,0), enc(1,2,2,6));
        chk("R6 memwb over wbend", op_b, memwb_result, sel_b, 2'd2);
        setup(enc(0,6,2,1), enc(0,1,1,2), enc(2,0,6,0), enc(1,2,2,6));
        chk("R9 a memwb", op_a, memwb_result, sel_a, 2'd2);
        chk("R9 b exmem", op_b, exmem_result, sel_b, 2'd1);
    endtask

    task automatic t_nonwriters;
        for (int op = 3; op <= 6; op++) begin
            setup(enc(0,4,4,1), enc(op,4,4,4), NOOP, NOOP);
            chk($sformatf("R7 op%0d", op), op_a, rf_a, sel_a, 2'd0);
        end
        setup(enc(0,4,4,1), NOOP, NOOP, enc(7,4,4,4));
        chk("R7 noop fields", op_b, rf_b, sel_b, 2'd0);
    endtask

    task automatic t_zero_reg;
        setup(enc(0,0,0,1), enc(0,1,1,0), enc(2,1,0,0), NOOP);
        chk("R8 a", op_a, rf_a, sel_a, 2'd0);
        chk("R8 b", op_b, rf_b, sel_b, 2'd0);
    endtask

    initial begin
        rf_a = 32'hAAAA0001; rf_b = 32'hBBBB0002;
        exmem_result = 32'h11110011; memwb_result = 32'h22220022;
        wbend_result = 32'h33330033;
        idex_instr = NOOP; exmem_instr = NOOP; memwb_instr = NOOP; wbend_instr = NOOP;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_single_stage();
        t_load_dest();
        t_priority();
        t_nonwriters();
        t_zero_reg();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: value=timeout expected value=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule